// File: doc/BRIEF.md
# Backlight PWM Duty to Brightness Readback

This block takes the settings of a backlight pulse-width modulator and turns them back into a normalized 16-bit brightness level. The settings are a period value, a period bit-count that sets how many period bits are valid, a 16-bit active-duty value, and a flag that selects whether the duty carries a fractional part. The level is the duty expressed as a fraction of the period, scaled to a full 16-bit range and rounded. This lets firmware or a power manager recover the current brightness from whatever the modulator was last set to, even when the period width is chosen at run time.

A one-cycle `start` pulse captures the inputs. A radix-2 restoring divider then produces one quotient bit per clock. A closing step rounds the quotient, multiplies it back by the period and shifts it down with a rounding bit. The result lands in a register with a one-cycle `done` pulse. While the operation runs, `busy` is high and further `start` pulses have no effect.

Top module: `bl_readback`

## Requirements
- R1: The effective bit-count B equals `bitcnt_in`, except that a `bitcnt_in` of 0 or above 16 gives B = 16.
- R2: The period P is `period_in` masked to its low B bits. If the masked value is zero, P is 0xFFFF instead.
- R3: With `frac_en` = 0, the duty D is `duty_in` ANDed with ((2^B - 1) << (16 - B)) truncated to 16 bits. Only the top B duty bits survive.
- R4: With `frac_en` = 1, D is all 16 bits of `duty_in`.
- R5: With N = D << (B + 1) and Q = floor(N / P), R = floor((Q + 1) / 2) and M = R * P. `level` becomes floor(M / 2^B) plus bit (B - 1) of M.
- R6: On an accepting edge (`start` high while `busy` is low), all four inputs are captured. Later changes to them do not alter the result.
- R7: A `start` pulse while `busy` is high is ignored. It produces no extra `done` pulse and does not change the level.
- R8: `done` is high for exactly one cycle, on the 34th rising edge after the accepting edge. `level` changes only in that cycle and otherwise holds its value.
- R9: During reset, `busy`, `done` and `level` are all 0.
- R10: `busy` is high from the cycle after the accepting edge until the edge that raises `done`, and is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| period_in | input | 16 | Programmed period field |
| bitcnt_in | input | 5 | Period bit-count field (0 means 16) |
| duty_in | input | 16 | Programmed active duty field |
| frac_en | input | 1 | Fractional duty enable |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result-valid pulse |
| level | output | 16 | Registered normalized brightness |

## Verification
The assertions assume that `start` is a known value at every clock after reset. They also assume that an operation is counted from its accepting edge, so the latency counter in the checker restarts only when `start` meets an idle block. The stimulus drives every input on the falling edge and keeps `start` high for one cycle per request. It changes the data inputs right after acceptance, so R6 can be observed at the `level` port. It also issues one extra `start` in the middle of a busy window to exercise R7. The stimulus sweeps every bit-count from 0 to 16, plus out-of-range values, with both fractional settings. Each result is compared with a reference model in the bench.

// File: rtl/bl_pkg.sv
package bl_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bl_state_e;
endpackage

// File: rtl/bl_prep.sv
// Operand preparation: bit-count defaulting, period and duty masking,
// numerator build. Purely combinational on the raw inputs.
module bl_prep #(
  parameter int W = 16,
  localparam int BCW = $clog2(W + 1),
  localparam int QW  = 2 * W + 1
) (
  input  logic [W-1:0]   period,
  input  logic [BCW-1:0] bitcnt,
  input  logic [W-1:0]   duty,
  input  logic           frac,
  output logic [BCW-1:0] bc,
  output logic [W-1:0]   per,
  output logic [QW-1:0]  num
);
  localparam logic [BCW-1:0] WB = BCW'(W);

  logic [W-1:0] pmask;
  logic [W-1:0] per_m;
  logic [W-1:0] dmask;
  logic [W-1:0] dsel;

  always_comb begin
    bc    = ((bitcnt == '0) || (bitcnt > WB)) ? WB : bitcnt;
    pmask = W'(((W+1)'(1) << bc) - (W+1)'(1));
    per_m = period & pmask;
    per   = (per_m == '0) ? '1 : per_m;
    dmask = pmask << (WB - bc);
    dsel  = frac ? duty : (duty & dmask);
    num   = QW'(dsel) << ((BCW+1)'(bc) + (BCW+1)'(1));
  end
endmodule

// File: rtl/bl_div.sv
// Radix-2 restoring divider, one quotient bit per clock.
module bl_div #(
  parameter int W = 16,
  localparam int QW = 2 * W + 1,
  localparam int CW = $clog2(QW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [QW-1:0] dividend,
  input  logic [W-1:0]  divisor,
  output logic [QW-1:0] quo,
  output logic          q_ok
);
  logic [W-1:0]  rem_q,  rem_d;
  logic [QW-1:0] dvd_q,  dvd_d;
  logic [W-1:0]  dv_q,   dv_d;
  logic [CW-1:0] cnt_q,  cnt_d;
  logic          run_q,  run_d;
  logic          ok_q,   ok_d;
  logic          step_en;

  logic [W:0] shifted;
  logic [W:0] diff;
  logic       ge;

  always_comb begin
    shifted = {rem_q, dvd_q[QW-1]};
    diff    = shifted - {1'b0, dv_q};
    ge      = (shifted >= {1'b0, dv_q});
  end

  always_comb begin
    step_en = load | run_q | ok_q;
    rem_d   = rem_q;
    dvd_d   = dvd_q;
    dv_d    = dv_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    ok_d    = 1'b0;
    if (load) begin
      rem_d = '0;
      dvd_d = dividend;
      dv_d  = divisor;
      cnt_d = CW'(QW);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = ge ? diff[W-1:0] : shifted[W-1:0];
      dvd_d = {dvd_q[QW-2:0], ge};
      cnt_d = cnt_q - CW'(1);
      run_d = (cnt_q != CW'(1));
      ok_d  = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvd_q <= '0;
      dv_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      ok_q  <= 1'b0;
    end else if (step_en) begin
      rem_q <= rem_d;
      dvd_q <= dvd_d;
      dv_q  <= dv_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      ok_q  <= ok_d;
    end
  end

  assign quo  = dvd_q;
  assign q_ok = ok_q;
endmodule

// File: rtl/bl_round.sv
// Closing arithmetic: halve-and-round the quotient, multiply by the
// period, shift down by the bit-count with a rounding bit.
module bl_round #(
  parameter int W = 16,
  localparam int BCW = $clog2(W + 1),
  localparam int QW  = 2 * W + 1,
  localparam int PW  = QW + W
) (
  input  logic [QW-1:0]  quo,
  input  logic [W-1:0]   per,
  input  logic [BCW-1:0] bc,
  output logic [W-1:0]   res
);
  logic [QW-1:0] qr;
  logic [PW-1:0] prod;
  logic [PW-1:0] sh;
  logic          rb;
  logic [PW-1:0] sum;

  always_comb begin
    qr   = QW'(({1'b0, quo} + (QW+1)'(1)) >> 1);
    prod = PW'(qr) * PW'(per);
    sh   = prod >> bc;
    rb   = |(prod & (PW'(1) << (bc - BCW'(1))));
    sum  = sh + PW'(rb);
    res  = (|sum[PW-1:W]) ? '1 : sum[W-1:0];
  end
endmodule

// File: rtl/bl_readback.sv
module bl_readback #(
  parameter int W = 16,
  localparam int BCW = $clog2(W + 1),
  localparam int QW  = 2 * W + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   period_in,
  input  logic [BCW-1:0] bitcnt_in,
  input  logic [W-1:0]   duty_in,
  input  logic           frac_en,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   level
);
  import bl_pkg::*;

  bl_state_e st_q, st_d;

  logic [BCW-1:0] bc_c,  bc_q;
  logic [W-1:0]   per_c, per_q;
  logic [QW-1:0]  num_c;
  logic [QW-1:0]  quo;
  logic           q_ok;
  logic [W-1:0]   res;
  logic           accept;
  logic           fin;
  logic           done_q, done_d;
  logic [W-1:0]   lvl_q,  lvl_d;

  bl_prep #(.W(W)) u_prep (
    .period (period_in),
    .bitcnt (bitcnt_in),
    .duty   (duty_in),
    .frac   (frac_en),
    .bc     (bc_c),
    .per    (per_c),
    .num    (num_c)
  );

  bl_div #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .dividend (num_c),
    .divisor  (per_c),
    .quo      (quo),
    .q_ok     (q_ok)
  );

  bl_round #(.W(W)) u_round (
    .quo (quo),
    .per (per_q),
    .bc  (bc_q),
    .res (res)
  );

  always_comb begin
    accept = start && (st_q == ST_IDLE);
    fin    = (st_q == ST_RUN) && q_ok;
    st_d   = st_q;
    if (accept)   st_d = ST_RUN;
    else if (fin) st_d = ST_IDLE;
    done_d = fin;
    lvl_d  = fin ? res : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q  <= '0;
      per_q <= '0;
    end else if (accept) begin
      bc_q  <= bc_c;
      per_q <= per_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else if (fin) lvl_q <= lvl_d;
  end

  assign busy  = (st_q == ST_RUN);
  assign done  = done_q;
  assign level = lvl_q;
endmodule

// File: rtl/bl_readback_chk.sv
module bl_readback_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] level
);
  localparam int LAT = 2 * W + 2;
  localparam int LW  = $clog2(LAT + 2);

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (start && !busy) lat_q <= '0;
    else if (busy) lat_q <= lat_q + LW'(1);
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LW'(LAT)));

  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(level));

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  busy_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R9
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (!busy && !done && level == '0);
    end
  end
endmodule

bind bl_readback bl_readback_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .level (level)
);

// File: tb/sim_bl_readback.sv
`timescale 1ns/1ps
module sim_bl_readback;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] period_in;
  logic [4:0]  bitcnt_in;
  logic [15:0] duty_in;
  logic        frac_en;
  logic        busy;
  logic        done;
  logic [15:0] level;

  int n_chk = 0;
  int n_bad = 0;
  localparam int EXP_K = 35;

  bl_readback u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .period_in(period_in),
    .bitcnt_in(bitcnt_in), .duty_in(duty_in), .frac_en(frac_en),
    .busy(busy), .done(done), .level(level)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_level(input int unsigned per, input int unsigned bcin,
                                             input int unsigned duty, input bit frac);
    longint unsigned bc, pm, p, dm, d, num, quo, q, prod, res;
    bc   = (bcin == 0 || bcin > 16) ? 64'd16 : longint'(bcin);
    pm   = (64'd1 << bc) - 64'd1;
    p    = longint'(per) & pm;
    if (p == 0) p = 64'hFFFF;
    dm   = (pm << (64'd16 - bc)) & 64'hFFFF;
    d    = frac ? (longint'(duty) & 64'hFFFF) : (longint'(duty) & dm);
    num  = d << (bc + 64'd1);
    quo  = num / p;
    q    = (quo + 64'd1) >> 1;
    prod = q * p;
    res  = (prod >> bc) + ((prod >> (bc - 64'd1)) & 64'd1);
    return res[15:0];
  endfunction

  // One request, waits for done, checks busy and latency (R8, R10).
  task automatic run_op(input logic [15:0] per, input logic [4:0] bc, input logic [15:0] duty,
                        input logic frac, output logic [15:0] got);
    int k;
    @(negedge clk);
    period_in = per; bitcnt_in = bc; duty_in = duty; frac_en = frac; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after accept", {31'd0, busy}, 32'd1);
    k = 1;
    while (!done && k < 100) begin
      @(posedge clk); k++;
      @(negedge clk);
    end
    chk("R8 done latency", k, EXP_K);
    chk("R10 busy low with done", {31'd0, busy}, 32'd0);
    got = level;
    @(posedge clk);
    @(negedge clk);
    chk("R8 done single cycle", {31'd0, done}, 32'd0);
    chk("R8 level held", {16'd0, level}, {16'd0, got});
  endtask

  task automatic t_reset;
    chk("R9 busy in reset", {31'd0, busy}, 32'd0);
    chk("R9 done in reset", {31'd0, done}, 32'd0);
    chk("R9 level in reset", {16'd0, level}, 32'd0);
  endtask

  task automatic t_sweep;
    logic [15:0] got;
    logic [15:0] pers  [3] = '{16'h3A5C, 16'hFFFF, 16'h0000};
    logic [15:0] duties[3] = '{16'hC3E1, 16'h8000, 16'h1234};
    for (int b = 0; b <= 16; b++) begin
      for (int f = 0; f < 2; f++) begin
        for (int p = 0; p < 3; p++) begin
          run_op(pers[p], 5'(b), duties[p], f[0], got);
          chk($sformatf("R5 sweep bc=%0d frac=%0d pat=%0d", b, f, p), {16'd0, got},
              {16'd0, ref_level(pers[p], b, duties[p], f[0])});
        end
      end
    end
  endtask

  task automatic t_bitcnt_default;
    logic [15:0] g0, g16, g20;
    run_op(16'h9B3D, 5'd0,  16'h7E21, 1'b1, g0);
    run_op(16'h9B3D, 5'd16, 16'h7E21, 1'b1, g16);
    run_op(16'h9B3D, 5'd20, 16'h7E21, 1'b1, g20);
    chk("R1 bitcnt 0 as 16", {16'd0, g0}, {16'd0, g16});
    chk("R1 bitcnt 20 as 16", {16'd0, g20}, {16'd0, g16});
    chk("R1 bitcnt 16 model", {16'd0, g16}, {16'd0, ref_level(16'h9B3D, 16, 16'h7E21, 1'b1)});
  endtask

  task automatic t_period_zero;
    logic [15:0] got;
    run_op(16'h0100, 5'd8, 16'h8000, 1'b1, got);
    chk("R2 masked period zero", {16'd0, got}, 32'h8000);
  endtask

  task automatic t_frac_modes;
    logic [15:0] got;
    run_op(16'h000A, 5'd4, 16'hFFFF, 1'b0, got);
    chk("R3 duty masked frac off", {16'd0, got}, 32'hF000);
    run_op(16'h000A, 5'd4, 16'hFFFF, 1'b1, got);
    chk("R4 duty full frac on", {16'd0, got}, 32'hFFFF);
  endtask

  task automatic t_sample_and_ignore;
    int k;
    int extra;
    logic [15:0] expa;
    expa = ref_level(16'h0D7F, 12, 16'h5A5A, 1'b0);
    @(negedge clk);
    period_in = 16'h0D7F; bitcnt_in = 5'd12; duty_in = 16'h5A5A; frac_en = 1'b0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    period_in = 16'h0003; bitcnt_in = 5'd2; duty_in = 16'hFFFF; frac_en = 1'b1;
    k = 1;
    repeat (5) begin @(posedge clk); k++; @(negedge clk); end
    start = 1'b1;
    @(posedge clk); k++;
    @(negedge clk);
    start = 1'b0;
    while (!done && k < 100) begin
      @(posedge clk); k++;
      @(negedge clk);
    end
    chk("R7 latency unchanged by busy start", k, EXP_K);
    chk("R6 inputs sampled at accept", {16'd0, level}, {16'd0, expa});
    extra = 0;
    repeat (45) begin
      @(posedge clk);
      @(negedge clk);
      if (done) extra++;
    end
    chk("R7 no extra done", extra, 0);
    chk("R7 level unchanged", {16'd0, level}, {16'd0, expa});
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    period_in = '0; bitcnt_in = '0; duty_in = '0; frac_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_frac_modes();
    t_period_zero();
    t_bitcnt_default();
    t_sample_and_ignore();
    t_sweep();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule